// File: doc/BRIEF.md
# Low-Speed Oscillator and RTC Clock-Source Control Register

This block is a single 32-bit control and status register for the always-on, low-speed part of a chip. Software uses it to switch a 32 kHz external crystal oscillator on and off and to put it in bypass mode, where an external clock drives the pin directly. Software also reads back whether that oscillator has become stable, and picks once which clock feeds the real-time-clock kernel. The chosen source code and the oscillator enable and bypass controls leave the block as plain outputs for the clock tree.

The bus side is a request/ready handshake. A single `bus_req_i` selects the register, and a write is qualified by four byte-lane enables. The bus FSM has two states. In `BUS_IDLE`, a request is accepted in the same cycle (`bus_rdy_o` high) and the transition *accept* moves it to `BUS_GAP`. `BUS_GAP` holds ready low for one cycle and always returns to `BUS_IDLE` (*recover*). This inserts exactly one wait state between back-to-back accesses.

A second FSM runs on the slow clock and turns the enable into a ready flag:
- `OSC_OFF` goes to `OSC_START` (*power-up*) when the enable is seen.
- `OSC_START` goes back to `OSC_OFF` (*abort*) if the enable drops. It goes to `OSC_READY` (*stable*) after the start count.
- `OSC_READY` goes to `OSC_STOP` (*power-down*) when the enable is seen low.
- `OSC_STOP` goes back to `OSC_READY` (*resume*) if the enable returns. It goes to `OSC_OFF` (*drained*) after the stop count.

The ready flag crosses into the bus clock through a two-flop synchroniser. A separate backup-domain reset clears the clock-source selection and reopens it for writing.

Top module: `rtc_clkctl_reg`

## Requirements
- R1: Bit 0 is the oscillator enable. It is read/write through byte lane 0, 1 turns the oscillator on, and it drives `osc_en_o`.
- R2: Bit 1 is the read-only ready flag. It rises on the START_CNT-th (default 6) rising edge of `lsclk_i` at which the enable is sampled high, counting from the first edge after the enable is set, and writes to bit 1 have no effect.
- R3: After the enable is cleared, the ready flag falls on exactly the STOP_CNT-th (default 6) rising edge of `lsclk_i`. Until that edge it stays high.
- R4: Bit 2 is the bypass control, driven on `osc_byp_o`. A write updates it only if the enable was 0 before that write, so the write that sets the enable may also set bypass. At other times bypass is unchanged.
- R5: Bits 9:8 select the RTC source and drive `rtc_src_o`. The codes are 00 none, 01 external 32 kHz oscillator, 10 internal low-speed RC and 11 divided high-speed clock.
- R6: Once the source field is non-zero, all writes to bits 9:8 are ignored. Writing 00 while the field is 00 leaves it open.
- R7: `bkp_rst_ni` low returns the source field to 00 and reopens it for one more selection. Enable and bypass are not affected.
- R8: Bits 7:3 and 31:10 read as zero and ignore writes.
- R9: Byte lane 0 (`bus_be_i[0]`) updates bits 7:0 and byte lane 1 updates bits 15:8. A write touches only its enabled lanes, and lanes 2 and 3 change nothing.
- R10: In the idle state a request sees `bus_rdy_o` high in the same cycle. The cycle after any completed access always has `bus_rdy_o` low. Read data is valid on `bus_rdata_o` while `bus_rdy_o` is high.
- R11: `rst_ni` low clears enable, bypass and the ready flag but keeps the source field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | System reset, active low |
| bkp_rst_ni | input | 1 | Backup-domain reset, active low; clears the source lock |
| lsclk_i | input | 1 | Low-speed oscillator clock model |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_be_i | input | 4 | Byte-lane enables for writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with ready on a read |
| bus_rdy_o | output | 1 | Access completes in this cycle |
| osc_en_o | output | 1 | Oscillator enable |
| osc_byp_o | output | 1 | Oscillator bypass |
| rtc_src_o | output | 2 | Selected RTC clock-source code |

## Verification
A wrong lock state shows up as a change in `rtc_src_o` on the bus cycle right after a refused write, or as a reopened field that fails to accept a code after backup reset. A slow-clock FSM stuck in the wrong state, or a miscounted stabilisation counter, shifts the ready flag by at least one `lsclk_i` period. That shift is seen at the register two bus cycles after the slow edge. So the bench reads the flag one edge before and one edge after the expected edge. A handshake FSM that skips its gap state is seen at once, as ready high in two successive cycles of a held request.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

    localparam int REG_W   = 32;
    localparam int LANES   = REG_W / 8;
    localparam int BIT_EN  = 0;
    localparam int BIT_RDY = 1;
    localparam int BIT_BYP = 2;
    localparam int SRC_LSB = 8;
    localparam int SRC_W   = 2;
    localparam int LANE_CTL = BIT_EN / 8;
    localparam int LANE_SRC = SRC_LSB / 8;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE    = 2'b00,
        SRC_XTAL32  = 2'b01,
        SRC_RC_LOW  = 2'b10,
        SRC_HS_DIV  = 2'b11
    } src_t;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_GAP  = 1'b1
    } bus_st_t;

    typedef enum logic [1:0] {
        OSC_OFF   = 2'b00,
        OSC_START = 2'b01,
        OSC_READY = 2'b10,
        OSC_STOP  = 2'b11
    } osc_st_t;

endpackage

// File: rtl/rtcc_bus_fsm.sv
module rtcc_bus_fsm
    import rtcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic rdy
);

    bus_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_IDLE: if (req) st_d = BUS_GAP;
            BUS_GAP:  st_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BUS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        rdy = 1'b0;
        unique case (st_q)
            BUS_IDLE: rdy = req;
            BUS_GAP:  rdy = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtcc_osc_track.sv
module rtcc_osc_track
    import rtcc_pkg::*;
#(
    parameter int START_CNT = 6,
    parameter int STOP_CNT  = 6
) (
    input  logic lsclk,
    input  logic rst_n,
    input  logic en,
    output logic rdy
);

    localparam int CNT_MAX = (START_CNT > STOP_CNT) ? START_CNT : STOP_CNT;
    localparam int CW      = $clog2(CNT_MAX + 1);

    osc_st_t        st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            OSC_OFF: begin
                if (en) begin
                    if (START_CNT <= 1) begin
                        st_d = OSC_READY;
                    end else begin
                        st_d  = OSC_START;
                        cnt_d = CW'(1);
                    end
                end
            end
            OSC_START: begin
                if (!en) begin
                    st_d  = OSC_OFF;
                    cnt_d = '0;
                end else if (cnt_q == CW'(START_CNT - 1)) begin
                    st_d  = OSC_READY;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            OSC_READY: begin
                if (!en) begin
                    if (STOP_CNT <= 1) begin
                        st_d = OSC_OFF;
                    end else begin
                        st_d  = OSC_STOP;
                        cnt_d = CW'(1);
                    end
                end
            end
            OSC_STOP: begin
                if (en) begin
                    st_d  = OSC_READY;
                    cnt_d = '0;
                end else if (cnt_q == CW'(STOP_CNT - 1)) begin
                    st_d  = OSC_OFF;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge lsclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= OSC_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge lsclk or negedge rst_n) begin
        if (!rst_n) rdy <= 1'b0;
        else        rdy <= (st_d == OSC_READY) || (st_d == OSC_STOP);
    end

endmodule

// File: rtl/rtcc_sync.sv
module rtcc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rtcc_regs.sv
module rtcc_regs
    import rtcc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bkp_rst_n,
    input  logic               wr,
    input  logic [LANES-1:0]   be,
    input  logic [REG_W-1:0]   wdata,
    input  logic               rdy_sync,
    output logic               en,
    output logic               byp,
    output src_t               src,
    output logic [REG_W-1:0]   value
);

    logic wr_ctl, wr_src;
    logic unused_wdata;

    assign wr_ctl = wr && be[LANE_CTL];
    assign wr_src = wr && be[LANE_SRC] && (src == SRC_NONE);
    assign unused_wdata = ^{wdata[REG_W-1:SRC_LSB+SRC_W], wdata[SRC_LSB-1:BIT_BYP+1],
                            wdata[BIT_RDY]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en  <= 1'b0;
            byp <= 1'b0;
        end else if (wr_ctl) begin
            en <= wdata[BIT_EN];
            if (!en) byp <= wdata[BIT_BYP];
        end
    end

    always_ff @(posedge clk or negedge bkp_rst_n) begin
        if (!bkp_rst_n)  src <= SRC_NONE;
        else if (wr_src) src <= src_t'(wdata[SRC_LSB +: SRC_W]);
    end

    always_comb begin
        value                      = '0;
        value[BIT_EN]              = en;
        value[BIT_RDY]             = rdy_sync;
        value[BIT_BYP]             = byp;
        value[SRC_LSB +: SRC_W]    = src;
    end

endmodule

// File: rtl/rtc_clkctl_reg.sv
module rtc_clkctl_reg
    import rtcc_pkg::*;
#(
    parameter int START_CNT   = 6,
    parameter int STOP_CNT    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        bkp_rst_ni,
    input  logic        lsclk_i,
    input  logic        bus_req_i,
    input  logic        bus_we_i,
    input  logic [3:0]  bus_be_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        bus_rdy_o,
    output logic        osc_en_o,
    output logic        osc_byp_o,
    output logic [1:0]  rtc_src_o
);

    logic             rdy_int;
    logic             rdy_ls;
    logic             rdy_bus;
    src_t             src;
    logic [REG_W-1:0] value;

    rtcc_bus_fsm u_bus (
        .clk   (clk_i),
        .rst_n (rst_ni),
        .req   (bus_req_i),
        .rdy   (rdy_int)
    );

    rtcc_regs u_regs (
        .clk       (clk_i),
        .rst_n     (rst_ni),
        .bkp_rst_n (bkp_rst_ni),
        .wr        (rdy_int && bus_we_i),
        .be        (bus_be_i),
        .wdata     (bus_wdata_i),
        .rdy_sync  (rdy_bus),
        .en        (osc_en_o),
        .byp       (osc_byp_o),
        .src       (src),
        .value     (value)
    );

    rtcc_osc_track #(
        .START_CNT (START_CNT),
        .STOP_CNT  (STOP_CNT)
    ) u_track (
        .lsclk (lsclk_i),
        .rst_n (rst_ni),
        .en    (osc_en_o),
        .rdy   (rdy_ls)
    );

    rtcc_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk_i),
        .rst_n (rst_ni),
        .d     (rdy_ls),
        .q     (rdy_bus)
    );

    assign bus_rdy_o   = rdy_int;
    assign bus_rdata_o = (rdy_int && !bus_we_i) ? value : '0;
    assign rtc_src_o   = src;

endmodule

// File: rtl/rtcc_chk.sv
module rtcc_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        bkp_rst_ni,
    input logic        bus_req_i,
    input logic        bus_we_i,
    input logic [3:0]  bus_be_i,
    input logic [31:0] bus_wdata_i,
    input logic [31:0] bus_rdata_o,
    input logic        bus_rdy_o,
    input logic        osc_en_o,
    input logic        osc_byp_o,
    input logic [1:0]  rtc_src_o
);

    assert_en_follows_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rdy_o && bus_we_i && bus_be_i[0]) |=> (osc_en_o == $past(bus_wdata_i[0])));

    assert_byp_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        osc_en_o |=> $stable(osc_byp_o));

    assert_src_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !bkp_rst_ni)
        (rtc_src_o != 2'b00) |=> $stable(rtc_src_o));

    assert_reserved_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rdy_o && !bus_we_i) |-> (bus_rdata_o[31:10] == '0 && bus_rdata_o[7:3] == '0));

    assert_rdy_needs_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rdy_o |-> bus_req_i);

    assert_gap_after_access_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rdy_o |=> !bus_rdy_o);

endmodule

bind rtc_clkctl_reg rtcc_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bkp_rst_ni  (bkp_rst_ni),
    .bus_req_i   (bus_req_i),
    .bus_we_i    (bus_we_i),
    .bus_be_i    (bus_be_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .bus_rdy_o   (bus_rdy_o),
    .osc_en_o    (osc_en_o),
    .osc_byp_o   (osc_byp_o),
    .rtc_src_o   (rtc_src_o)
);

// File: tb/sim_rtc_clkctl_reg.sv
`timescale 1ns/1ps
module sim_rtc_clkctl_reg;

    logic        clk_i = 1'b0;
    logic        lsclk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        bkp_rst_ni = 1'b0;
    logic        bus_req_i = 1'b0;
    logic        bus_we_i = 1'b0;
    logic [3:0]  bus_be_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        bus_rdy_o;
    logic        osc_en_o;
    logic        osc_byp_o;
    logic [1:0]  rtc_src_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rd;

    always #10 clk_i = ~clk_i;
    always #205 lsclk_i = ~lsclk_i;

    rtc_clkctl_reg u0 (.*);

    typedef struct packed {
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{4'h1, 32'h0000_0004, 32'h0000_0004},
        '{4'h1, 32'h0000_0005, 32'h0000_0005},
        '{4'h1, 32'h0000_0001, 32'h0000_0005},
        '{4'h1, 32'h0000_0000, 32'h0000_0004},
        '{4'h1, 32'h0000_0000, 32'h0000_0000},
        '{4'hC, 32'hFFFF_FFFF, 32'h0000_0000},
        '{4'h2, 32'h0000_00FF, 32'h0000_0000},
        '{4'h2, 32'h0000_0200, 32'h0000_0200},
        '{4'h3, 32'h0000_0101, 32'h0000_0201},
        '{4'hF, 32'hFFFF_FFF8, 32'h0000_0200},
        '{4'hF, 32'h0000_0007, 32'h0000_0205},
        '{4'h1, 32'h0000_0000, 32'h0000_0204},
        '{4'h1, 32'h0000_0000, 32'h0000_0200}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [3:0] be, input logic [31:0] wd,
                        output logic [31:0] rdata);
        @(negedge clk_i);
        bus_req_i   = 1'b1;
        bus_we_i    = we;
        bus_be_i    = be;
        bus_wdata_i = wd;
        #1;
        while (!bus_rdy_o) begin
            @(negedge clk_i);
            #1;
        end
        rdata = bus_rdata_o;
        @(posedge clk_i);
        #1;
        bus_req_i = 1'b0;
        bus_we_i  = 1'b0;
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] wd);
        logic [31:0] dummy;
        xfer(1'b1, be, wd, dummy);
    endtask

    task automatic rdreg(output logic [31:0] v);
        xfer(1'b0, 4'h0, 32'h0, v);
    endtask

    initial begin
        repeat (20000) @(posedge clk_i);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk_i);
        rst_ni     = 1'b1;
        bkp_rst_ni = 1'b1;
        repeat (2) @(negedge clk_i);

        // R11 / R5: reset state
        rdreg(rd);
        check("R11 reset value", rd, 32'h0);
        check("R5 reset source output", {30'h0, rtc_src_o}, 32'h0);

        // R1 R4 R6 R8 R9: vector walk, ready bit masked
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].be, VEC[i].wd);
            rdreg(rd);
            check($sformatf("R9 vector %0d readback", i), rd & ~32'h2, VEC[i].exp);
            check($sformatf("R5 vector %0d source pins", i),
                  {30'h0, rtc_src_o}, {30'h0, VEC[i].exp[9:8]});
            check($sformatf("R1 vector %0d enable pin", i),
                  {31'h0, osc_en_o}, {31'h0, VEC[i].exp[0]});
        end

        // R2: ready rises on the 6th slow edge with enable high
        repeat (2) @(posedge lsclk_i);
        wr(4'h1, 32'h0000_0003);
        repeat (5) @(posedge lsclk_i);
        repeat (5) @(posedge clk_i);
        rdreg(rd);
        check("R2 ready low after 5 slow edges", rd, 32'h0000_0201);
        @(posedge lsclk_i);
        repeat (5) @(posedge clk_i);
        rdreg(rd);
        check("R2 ready high after 6 slow edges", rd, 32'h0000_0203);

        // R2: writing bit 1 low has no effect
        wr(4'h1, 32'h0000_0001);
        rdreg(rd);
        check("R2 ready bit read-only", rd, 32'h0000_0203);

        // R3: ready falls on the 6th slow edge after disable
        wr(4'h1, 32'h0000_0000);
        repeat (5) @(posedge lsclk_i);
        repeat (5) @(posedge clk_i);
        rdreg(rd);
        check("R3 ready held 5 edges after disable", rd, 32'h0000_0202);
        @(posedge lsclk_i);
        repeat (5) @(posedge clk_i);
        rdreg(rd);
        check("R3 ready dropped on 6th edge", rd, 32'h0000_0200);

        // R7: backup reset reopens source, keeps bypass
        wr(4'h1, 32'h0000_0004);
        @(negedge clk_i);
        bkp_rst_ni = 1'b0;
        repeat (3) @(negedge clk_i);
        bkp_rst_ni = 1'b1;
        rdreg(rd);
        check("R7 backup reset clears source only", rd, 32'h0000_0004);
        wr(4'h2, 32'h0000_0100);
        rdreg(rd);
        check("R7 source writable after backup reset", rd, 32'h0000_0104);
        wr(4'h2, 32'h0000_0300);
        rdreg(rd);
        check("R6 relock ignores second code", rd, 32'h0000_0104);
        check("R5 source output code 01", {30'h0, rtc_src_o}, 32'h1);

        // R10: handshake timing on a held read request
        repeat (3) @(negedge clk_i);
        bus_req_i = 1'b1;
        bus_we_i  = 1'b0;
        #1;
        check("R10 idle access ready at once", {31'h0, bus_rdy_o}, 32'h1);
        check("R10 read data valid with ready", bus_rdata_o, 32'h0000_0104);
        @(negedge clk_i);
        #1;
        check("R10 wait state after access", {31'h0, bus_rdy_o}, 32'h0);
        @(negedge clk_i);
        #1;
        check("R10 ready again after gap", {31'h0, bus_rdy_o}, 32'h1);
        @(posedge clk_i);
        #1;
        bus_req_i = 1'b0;

        // R11: system reset keeps source, clears enable and bypass
        wr(4'h1, 32'h0000_0001);
        @(negedge clk_i);
        rst_ni = 1'b0;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        repeat (2) @(negedge clk_i);
        rdreg(rd);
        check("R11 system reset keeps source", rd, 32'h0000_0100);
        check("R11 enable pin cleared", {30'h0, osc_byp_o, osc_en_o}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule